// File: doc/BRIEF.md
# UART Receive Buffer with Character Timeout

This block is the receive side storage of a UART. Bytes and break events arrive from a deserializer. A host reads the data port and the line-status port, and writes a control byte. The control byte selects one of two modes. In queue mode, a 16-entry first-in first-out buffer holds the bytes and a trigger level is compared with the fill count. In single-register mode, each new byte replaces the one before it. The block keeps three line-status flags: data-ready, overrun and break. It also runs a silence counter, which raises a timeout flag when stored bytes sit untouched for four character frames.

The deserializer side is a valid/ready stream. `rx_ready` is held high at all times, because a serial line cannot be paused. Any byte that finds no room is therefore dropped and recorded as an overrun. No byte is lost silently. The frame length that the timeout uses comes from the `line_fmt` pins, and time is counted in `bit_tick` pulses, one pulse per serial bit period.

When several events occur in the same cycle, they are applied in a fixed order. A receive flush comes first. A data read comes next. An arriving byte or break comes last. An arrival therefore lands in storage that the flush has just emptied, or in the slot that the read has just freed.

Top module: `uart_rx_buffer`

## Requirements
- R1: In queue mode (control bit 0 = 1), bytes are read back in arrival order. `fifo_level` reports the count, from 0 to 16.
- R2: A byte that arrives while the queue holds 16 bytes is discarded. The stored bytes are kept, and `oe` is set.
- R3: Control bits 7:6 select the trigger level: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. In queue mode `level_hit` is high when `fifo_level` is at or above the trigger level. In single-register mode `level_hit` follows `dr`.
- R4: A control write keeps only bits 7, 6, 3 and 0 (mask 0xC9), and these appear on `ctl_q`. A write whose value equals `ctl_q` has no effect. Bit 1 empties the receive storage, clears `dr` and cancels a pending timeout. Bit 2 gives a one-cycle `tx_flush` pulse in the next cycle. A change of bit 0 forces both flushes.
- R5: A `rx_break` pulse stores the byte 0x00 and sets both `bi` and `dr`.
- R6: A line-status read (`rd_lsr_en`) clears `bi` and `oe` at the next edge. A break or overrun in the same cycle takes precedence.
- R7: A data read that removes the last queued byte clears `dr` and `bi`. A data read from an empty queue returns 0x00 and leaves `fifo_level` at 0.
- R8: In single-register mode (control bit 0 = 0), a byte that arrives while `dr` is set sets `oe` and replaces the stored byte.
- R9: One character lasts F bit ticks, where F = 1 + (5 + line_fmt[1:0]) + line_fmt[3] + (line_fmt[2] ? 2 : 1). `timeout_pend` rises after 4·F ticks with a non-empty queue and no read or arrival. Each arrival or data read restarts the count.
- R10: A data read clears `timeout_pend`. The count is held at zero while the queue is empty or the block is in single-register mode.
- R11: `rx_ready` is always 1. A data read and an arrival in the same cycle return the old head byte and then store the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Always 1; the block never stalls the deserializer |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break event; stored as a 0x00 byte |
| rd_data_en | input | 1 | Host data read strobe (pops one byte) |
| rd_data | output | 8 | Read data; valid in the cycle that `rd_data_en` is high |
| rd_lsr_en | input | 1 | Host line-status read strobe |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write value |
| ctl_q | output | 8 | Retained control bits |
| tx_flush | output | 1 | One-cycle request to flush the transmit side |
| line_fmt | input | 4 | Frame format: [1:0] data bits minus 5, [2] two stop bits, [3] parity present |
| bit_tick | input | 1 | One pulse per serial bit period |
| fifo_level | output | 5 | Number of queued bytes |
| dr | output | 1 | Data-ready flag |
| oe | output | 1 | Overrun flag |
| bi | output | 1 | Break flag |
| level_hit | output | 1 | Count at or above the trigger level |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
A wrong read or write pointer shows up in the first read after the pointer breaks: the byte returned is out of order. The sweep that fills the queue and then drains all 16 bytes at each trigger setting catches such an error within 16 reads. A miscounted fill level shows up the same way, with delays of up to 16 cycles: `level_hit` or `oe` appears at the wrong fill count, or `dr` fails to clear on the last read. A wrong frame length or timeout limit moves the rise of `timeout_pend` by at least one tick. The bench checks this for every one of the 16 line formats, one tick before the expected edge and again at it.

// File: rtl/uart_rxb_pkg.sv
`timescale 1ns/1ps
package uart_rxb_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_FRAME = 12;
  localparam int TMO_W     = $clog2(4 * MAX_FRAME + 1);
  localparam logic [7:0] CTL_KEEP = 8'hC9;

  // trigger threshold selected by control bits 7:6
  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // bits in one serial character: start + data + optional parity + stop
  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    logic [3:0] n;
    n = 4'd6 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]};
    n = n + (fmt[2] ? 4'd2 : 4'd1);
    return n;
  endfunction
endpackage

// File: rtl/rxb_ring.sv
`timescale 1ns/1ps
module rxb_ring #(
  parameter int DEPTH = 16,
  parameter int W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pop,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic          accepted
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic          do_pop, full_now;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    do_pop   = pop && (level != '0) && !clr;
    full_now = (level == CW'(DEPTH));
    // a flush empties first; otherwise a same-cycle pop frees a slot
    accepted = push && (clr || !full_now || do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      level <= '0;
    end else if (clr) begin
      rptr  <= '0;
      wptr  <= accepted ? AW'(1) : '0;
      level <= accepted ? CW'(1) : '0;
    end else begin
      if (do_pop)   rptr <= step(rptr);
      if (accepted) wptr <= step(wptr);
      level <= level + CW'(accepted) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (accepted) mem[clr ? '0 : wptr] <= din;
  end

  assign head = mem[rptr];
endmodule

// File: rtl/rxb_ctl_reg.sv
`timescale 1ns/1ps
module rxb_ctl_reg
  import uart_rxb_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [7:0]    wdata,
  output logic [7:0]    ctl_q,
  output logic          fen_now,
  output logic          fen_next,
  output logic [CW-1:0] trig,
  output logic          rx_flush,
  output logic          tx_flush
);
  logic eff, en_chg, tx_req;

  always_comb begin
    eff      = we && (wdata != ctl_q);
    en_chg   = eff && (wdata[0] != ctl_q[0]);
    rx_flush = eff && (wdata[1] || en_chg);
    tx_req   = eff && (wdata[2] || en_chg);
    fen_next = eff ? wdata[0] : ctl_q[0];
    fen_now  = ctl_q[0];
    trig     = CW'(trig_level(ctl_q[7:6]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      tx_flush <= 1'b0;
    end else begin
      if (eff) ctl_q <= wdata & CTL_KEEP;
      tx_flush <= tx_req;
    end
  end
endmodule

// File: rtl/rxb_char_timer.sv
`timescale 1ns/1ps
module rxb_char_timer
  import uart_rxb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] fmt,
  input  logic       restart,
  input  logic       run,
  input  logic       clr_pend,
  output logic       pend
);
  logic [TMO_W-1:0] cnt, limit;

  assign limit = TMO_W'(frame_bits(fmt)) << 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (clr_pend) pend <= 1'b0;
      if (restart || !run || pend) begin
        cnt <= '0;
      end else if (tick) begin
        if ((cnt + TMO_W'(1)) >= limit) begin
          pend <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + TMO_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_buffer.sv
`timescale 1ns/1ps
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_break,
  input  logic              rd_data_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              rd_lsr_en,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_q,
  output logic              tx_flush,
  input  logic [3:0]        line_fmt,
  input  logic              bit_tick,
  output logic [CW-1:0]     fifo_level,
  output logic              dr,
  output logic              oe,
  output logic              bi,
  output logic              level_hit,
  output logic              timeout_pend
);
  logic              fen, fen_nxt, rx_flush, ring_acc;
  logic [CW-1:0]     trig;
  logic [BYTE_W-1:0] head, hold_q, abyte;
  logic              arrival, rd_empties, ovr;
  logic              dr_n, oe_n, bi_n;

  assign rx_ready = 1'b1;
  assign arrival  = rx_valid || rx_break;
  assign abyte    = rx_break ? '0 : rx_data;

  rxb_ctl_reg #(.CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .ctl_q(ctl_q), .fen_now(fen), .fen_next(fen_nxt), .trig(trig),
    .rx_flush(rx_flush), .tx_flush(tx_flush)
  );

  rxb_ring #(.DEPTH(DEPTH), .W(BYTE_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(rx_flush),
    .pop(rd_data_en && fen), .push(arrival && fen_nxt), .din(abyte),
    .head(head), .level(fifo_level), .accepted(ring_acc)
  );

  rxb_char_timer u_tmo (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .fmt(line_fmt),
    .restart(arrival || rd_data_en || rx_flush),
    .run(fen && (fifo_level != '0)),
    .clr_pend(rd_data_en || rx_flush),
    .pend(timeout_pend)
  );

  // single-register mode storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (arrival && !fen_nxt) hold_q <= abyte;
  end

  always_comb begin
    if (fen) rd_data = (fifo_level != '0) ? head : '0;
    else     rd_data = hold_q;
  end

  // line status: flush, then read, then arrival
  always_comb begin
    rd_empties = rd_data_en && !rx_flush && (!fen || fifo_level <= CW'(1));
    ovr = arrival && (fen_nxt ? !ring_acc : (dr && !rd_data_en && !rx_flush));
    dr_n = dr;
    oe_n = oe;
    bi_n = bi;
    if (rx_flush) dr_n = 1'b0;
    if (rd_empties) begin
      dr_n = 1'b0;
      bi_n = 1'b0;
    end
    if (rd_lsr_en) begin
      oe_n = 1'b0;
      bi_n = 1'b0;
    end
    if (arrival)  dr_n = 1'b1;
    if (rx_break) bi_n = 1'b1;
    if (ovr)      oe_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr <= 1'b0;
      oe <= 1'b0;
      bi <= 1'b0;
    end else begin
      dr <= dr_n;
      oe <= oe_n;
      bi <= bi_n;
    end
  end

  assign level_hit = fen ? (fifo_level >= trig) : dr;
endmodule

// File: rtl/rxb_checker.sv
`timescale 1ns/1ps
module rxb_checker #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          rd_data_en,
  input logic          rd_lsr_en,
  input logic          ctl_we,
  input logic [7:0]    ctl_q,
  input logic [CW-1:0] fifo_level,
  input logic          dr,
  input logic          oe,
  input logic          bi,
  input logic          timeout_pend
);
  logic arr;
  assign arr = rx_valid || rx_break;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(DEPTH)); // R1

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && fifo_level == CW'(DEPTH) && arr && !rd_data_en && !ctl_we)
    |=> (oe && fifo_level == CW'(DEPTH))); // R2

  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr_en && !arr) |=> (!oe && !bi)); // R6

  AST_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && fifo_level == CW'(1) && rd_data_en && !arr && !ctl_we)
    |=> (!dr && !bi && fifo_level == '0)); // R7

  AST_SINGLE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[0] && !ctl_we && dr && rx_valid && !rd_data_en) |=> (oe && dr)); // R8

  AST_DR_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] |-> (dr == (fifo_level != '0))); // R1

  AST_PEND_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pend |-> (fifo_level != '0)); // R10
endmodule

bind uart_rx_buffer rxb_checker #(.DEPTH(DEPTH)) u_rxb_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
  .rd_data_en(rd_data_en), .rd_lsr_en(rd_lsr_en), .ctl_we(ctl_we),
  .ctl_q(ctl_q), .fifo_level(fifo_level), .dr(dr), .oe(oe), .bi(bi),
  .timeout_pend(timeout_pend)
);

// File: tb/uart_rx_buffer_test.sv
`timescale 1ns/1ps
module uart_rx_buffer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_break = 1'b0, rd_data_en = 1'b0;
  logic       rd_lsr_en = 1'b0, ctl_we = 1'b0, bit_tick = 1'b0;
  logic [7:0] rx_data = '0, ctl_wdata = '0;
  logic [3:0] line_fmt = '0;
  logic       rx_ready, tx_flush, dr, oe, bi, level_hit, timeout_pend;
  logic [7:0] rd_data, ctl_q;
  logic [4:0] fifo_level;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_buffer uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_break(rx_break), .rd_data_en(rd_data_en),
    .rd_data(rd_data), .rd_lsr_en(rd_lsr_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .tx_flush(tx_flush),
    .line_fmt(line_fmt), .bit_tick(bit_tick), .fifo_level(fifo_level),
    .dr(dr), .oe(oe), .bi(bi), .level_hit(level_hit),
    .timeout_pend(timeout_pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic brk();
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    rd_data_en = 1'b1;
    #1 b = rd_data;
    @(negedge clk);
    rd_data_en = 1'b0;
  endtask

  task automatic lsr_rd();
    rd_lsr_en = 1'b1;
    @(negedge clk);
    rd_lsr_en = 1'b0;
  endtask

  task automatic wctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    bit_tick = 1'b1;
    repeat (n) @(negedge clk);
    bit_tick = 1'b0;
  endtask

  function automatic int trig_of(input int t);
    return (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
  endfunction

  function automatic int char_ticks(input int f);
    return 1 + 5 + (f & 3) + ((f >> 3) & 1) + (((f >> 2) & 1) ? 2 : 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R4 reset ctl", ctl_q, 0);
    chk("R1 reset level", fifo_level, 0);
    chk("R7 reset dr/oe/bi", {dr, oe, bi}, 0);
    chk("R10 reset pend", timeout_pend, 0);
    chk("R11 ready", rx_ready, 1);

    // single-register mode
    push(8'hA5);
    chk("R8 dr set", dr, 1);
    chk("R3 hit follows dr", level_hit, 1);
    chk("R8 no overrun yet", oe, 0);
    ticks(60);
    chk("R10 no timeout single mode", timeout_pend, 0);
    push(8'h3C);
    chk("R8 overrun set", oe, 1);
    rd(b);
    chk("R8 byte replaced", b, 8'h3C);
    chk("R8 dr cleared", dr, 0);
    chk("R3 hit follows dr low", level_hit, 0);
    lsr_rd();
    chk("R6 oe cleared", oe, 0);

    // control register
    wctl(8'h01);
    chk("R4 enable stored", ctl_q, 8'h01);
    chk("R4 enable change flushes tx", tx_flush, 1);
    @(negedge clk);
    chk("R4 tx pulse one cycle", tx_flush, 0);
    wctl(8'h01);
    chk("R4 equal write ignored", tx_flush, 0);
    wctl(8'hFF);
    chk("R4 mask C9", ctl_q, 8'hC9);
    chk("R4 bit2 tx flush", tx_flush, 1);

    // trigger sweep, fill, overflow, drain
    for (int t = 0; t < 4; t++) begin
      wctl(8'((t << 6) | 3));
      chk("R4 flush empties", fifo_level, 0);
      for (int n = 1; n <= 16; n++) begin
        push(8'((t * 37 + n * 11) & 255));
        chk("R1 level count", fifo_level, n);
        chk("R3 trigger compare", level_hit, (n >= trig_of(t)) ? 1 : 0);
      end
      chk("R2 no overrun at 16", oe, 0);
      push(8'hEE);
      chk("R2 overrun on full", oe, 1);
      chk("R2 level held", fifo_level, 16);
      for (int n = 1; n <= 16; n++) begin
        rd(b);
        chk("R1 order", b, (t * 37 + n * 11) & 255);
        chk("R1 level drain", fifo_level, 16 - n);
      end
      chk("R7 last read clears dr", dr, 0);
      rd(b);
      chk("R7 empty read data", b, 0);
      chk("R7 empty read level", fifo_level, 0);
      lsr_rd();
      chk("R6 oe cleared", oe, 0);
    end

    // break
    push(8'h11);
    brk();
    chk("R5 break stored", fifo_level, 2);
    chk("R5 bi and dr", {bi, dr}, 2'b11);
    rd(b);
    chk("R5 byte before break", b, 8'h11);
    chk("R7 bi kept while data remains", bi, 1);
    rd(b);
    chk("R5 break byte zero", b, 0);
    chk("R7 last read clears bi/dr", {bi, dr}, 0);
    brk();
    lsr_rd();
    chk("R6 lsr clears bi", bi, 0);
    chk("R6 dr unchanged", dr, 1);
    rd(b);

    // character timeout over all line formats
    for (int f = 0; f < 16; f++) begin
      line_fmt = 4'(f);
      push(8'h5A);
      ticks(4 * char_ticks(f) - 1);
      chk("R9 not yet pending", timeout_pend, 0);
      ticks(1);
      chk("R9 pending at 4 chars", timeout_pend, 1);
      rd(b);
      chk("R10 read clears pend", timeout_pend, 0);
    end
    line_fmt = 4'd0;
    push(8'h01);
    ticks(27);
    push(8'h02);
    ticks(27);
    chk("R9 arrival restarts", timeout_pend, 0);
    ticks(1);
    chk("R9 pending after restart", timeout_pend, 1);
    rd(b);
    rd(b);
    ticks(100);
    chk("R10 held while empty", timeout_pend, 0);

    // receive flush with data
    push(8'h21);
    push(8'h22);
    wctl(8'hC3);
    chk("R4 rx flush level", fifo_level, 0);
    chk("R4 rx flush dr", dr, 0);
    chk("R4 no tx flush", tx_flush, 0);
    chk("R4 flush bit not kept", ctl_q, 8'hC1);

    // same-cycle read and arrival
    push(8'h77);
    rd_data_en = 1'b1; rx_valid = 1'b1; rx_data = 8'h88;
    #1 b = rd_data;
    @(negedge clk);
    rd_data_en = 1'b0; rx_valid = 1'b0;
    chk("R11 read returns old head", b, 8'h77);
    chk("R11 level after read+arrival", fifo_level, 1);
    chk("R11 dr stays", dr, 1);
    rd(b);
    chk("R11 new byte stored", b, 8'h88);

    // overflow concurrent with lsr read
    for (int n = 0; n < 16; n++) push(8'(n));
    rd_lsr_en = 1'b1; rx_valid = 1'b1; rx_data = 8'h99;
    @(negedge clk);
    rd_lsr_en = 1'b0; rx_valid = 1'b0;
    chk("R6 overrun wins over lsr read", oe, 1);
    rd(b);
    chk("R2 contents kept", b, 0);
    lsr_rd();
    chk("R6 oe cleared after read", oe, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule